// File: doc/BRIEF.md
# SPI Command Decoder for a Parallel NAND Port

This block is an SPI slave clocked by the system clock. It turns each chip-select frame from a host processor into activity on an 8-bit parallel NAND flash port and on a small set of board outputs. The first byte of every frame is an opcode. The opcode sets how the later bytes in that frame are used:

- as NAND write data,
- as a configuration byte,
- as turnaround (dummy) bytes, or
- as slots in which NAND read data is shifted back to the host.

A configuration register drives four user LEDs, a fan enable and the NAND address-latch, command-latch and active-low chip-enable lines. An auxiliary LED has its own opcodes to switch it on and off.

The SPI lines are oversampled in the system clock domain through synchronizers. Each SCK half period must therefore last at least four system clocks. Writes to NAND lag the SPI stream by one byte, and reads are prefetched one byte ahead. This lets a completed SPI byte always have a whole byte period to turn into a strobe or a shift-register load. The NAND data bus is split into an output, an output enable and an input, so the pad tristate sits outside the block.

Top module: `spinand_bridge`

## Requirements
- R1: SPI runs in mode 0, MSB first, and bytes are counted from the falling edge of chip select. Every byte that follows opcode 0x09 in the same frame loads the configuration register, and the last one wins. The register bits map as follows: bits 3..0 drive `led_user[3:0]`, bit 4 drives `fan_en`, bit 5 drives `nand_ale`, bit 6 drives `nand_cle` and bit 7 drives `nand_ce_n`.
- R2: After reset the configuration register holds 0x80, so the NAND is deselected and every other output is low. Also after reset, `led_aux` is 0, `nand_we_n` and `nand_re_n` are 1, `nand_doe` is 0 and `spi_miso` is 0.
- R3: After opcode 0x08, each byte is written to the NAND when the next byte of the frame completes, so a trailing idle byte flushes the final data byte. The last byte before chip select rises is never written.
- R4: During a write strobe `nand_doe` is 1 and `nand_dout` holds the byte. `nand_we_n` stays low for exactly STROBE_CLKS system clocks, and `nand_doe` returns to 0 one clock after `nand_we_n` rises.
- R5: Opcode 0x0A is followed by one idle byte, during which MISO is 0. Each later byte slot returns the next byte read from the NAND, MSB first.
- R6: Opcode 0x0B is followed by four idle bytes, during which MISO is 0, before NAND read data is returned.
- R7: Opcode 0x0C sets `led_aux` to 1 and opcode 0x0D clears it.
- R8: Any other opcode makes the rest of its frame ignored. The configuration, `led_aux` and both NAND strobes are untouched, and MISO stays 0.
- R9: When chip select rises at any point, the decoder returns to waiting for an opcode and a partial byte is discarded. MISO is 0 while chip select is high.
- R10: If the rise of chip select is sampled in the same system clock as the eighth SCK rising edge of a byte, that byte is discarded.
- R11: `nand_re_n` stays low for exactly STROBE_CLKS system clocks per read, and the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| nand_dout | output | 8 | NAND I/O bus output value |
| nand_doe | output | 1 | NAND I/O bus output enable |
| nand_din | input | 8 | NAND I/O bus input value |
| nand_we_n | output | 1 | NAND write enable, active low |
| nand_re_n | output | 1 | NAND read enable, active low |
| nand_ale | output | 1 | NAND address latch enable |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| led_user | output | 4 | User LEDs from the configuration |
| led_aux | output | 1 | Auxiliary LED set by opcode |
| fan_en | output | 1 | Fan enable |

## Verification
The collision that matters here is the end of a frame landing in the same sampled cycle as the completion of a byte. In that case the byte-complete strobe and the return to the opcode-wait state compete for the decoder. The bench provokes this by raising SCK and chip select together on the last bit of a configuration byte. It then judges the result by checking that the configuration outputs still show the previous value. A second overlap is read prefetch against shift-register load: when a byte completes in a read frame, the prefetched byte is loaded and the next NAND read is launched in the same cycle. The bench checks this by comparing every returned byte with the NAND model's read sequence.

// File: rtl/spinand_pkg.sv
package spinand_pkg;

  localparam logic [7:0] OP_NAND_WR      = 8'h08;
  localparam logic [7:0] OP_CFG_WR       = 8'h09;
  localparam logic [7:0] OP_NAND_RD      = 8'h0A;
  localparam logic [7:0] OP_NAND_RD_FAST = 8'h0B;
  localparam logic [7:0] OP_AUX_ON       = 8'h0C;
  localparam logic [7:0] OP_AUX_OFF      = 8'h0D;

  localparam int IDLE_W          = 3;
  localparam int IDLE_BYTES_NORM = 1;
  localparam int IDLE_BYTES_FAST = 4;

  localparam int CFG_FAN  = 4;
  localparam int CFG_ALE  = 5;
  localparam int CFG_CLE  = 6;
  localparam int CFG_CE_N = 7;

  typedef enum logic [2:0] {
    SQ_OPCODE,
    SQ_WRITE,
    SQ_CONFIG,
    SQ_RDWAIT,
    SQ_RDATA,
    SQ_DISCARD
  } seq_state_e;

  typedef enum logic [1:0] {
    NP_IDLE,
    NP_WE_LOW,
    NP_WE_HOLD,
    NP_RE_LOW
  } nand_phase_e;

endpackage

// File: rtl/spinand_sync.sv
module spinand_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spinand_spi_link.sv
module spinand_spi_link #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic       tx_load,
  input  logic [7:0] tx_word,
  output logic       miso,
  output logic       frame_idle,
  output logic       byte_stb,
  output logic [7:0] rx_byte
);

  logic       sck_s, cs_s, mosi_s;
  logic       sck_q;
  logic       sck_rise, sck_fall;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;

  spinand_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({sck, cs_n, mosi}),
    .q  ({sck_s, cs_s, mosi_s})
  );

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  // Frame release has priority over any edge seen in the same cycle.
  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else begin
      if (sck_rise) begin
        rx_sh   <= {rx_sh[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (tx_load) tx_sh <= tx_word;
      else if (sck_fall && bit_cnt != 3'd0) tx_sh <= {tx_sh[6:0], 1'b0};
    end
  end

  assign byte_stb   = sck_rise & ~cs_s & (bit_cnt == 3'd7);
  assign rx_byte    = {rx_sh, mosi_s};
  assign miso       = tx_sh[7];
  assign frame_idle = cs_s;

endmodule

// File: rtl/spinand_nand_port.sv
module spinand_nand_port
  import spinand_pkg::*;
#(
  parameter int STROBE_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_req,
  input  logic [7:0] wr_byte,
  input  logic       rd_req,
  input  logic [7:0] nand_din,
  output logic [7:0] nand_dout,
  output logic       nand_doe,
  output logic       nand_we_n,
  output logic       nand_re_n,
  output logic [7:0] rd_byte
);

  localparam int CW = $clog2(STROBE_CLKS + 1);
  localparam logic [CW-1:0] CNT_START = CW'(STROBE_CLKS - 1);

  nand_phase_e      phase;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= NP_IDLE;
      cnt       <= '0;
      nand_dout <= '0;
      nand_doe  <= 1'b0;
      nand_we_n <= 1'b1;
      nand_re_n <= 1'b1;
      rd_byte   <= '0;
    end else begin
      unique case (phase)
        NP_IDLE: begin
          if (wr_req) begin
            nand_dout <= wr_byte;
            nand_doe  <= 1'b1;
            nand_we_n <= 1'b0;
            cnt       <= CNT_START;
            phase     <= NP_WE_LOW;
          end else if (rd_req) begin
            nand_re_n <= 1'b0;
            cnt       <= CNT_START;
            phase     <= NP_RE_LOW;
          end
        end
        NP_WE_LOW: begin
          if (cnt == '0) begin
            nand_we_n <= 1'b1;
            phase     <= NP_WE_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        NP_WE_HOLD: begin
          nand_doe <= 1'b0;
          phase    <= NP_IDLE;
        end
        NP_RE_LOW: begin
          if (cnt == '0) begin
            nand_re_n <= 1'b1;
            rd_byte   <= nand_din;
            phase     <= NP_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= NP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spinand_cmd_seq.sv
module spinand_cmd_seq
  import spinand_pkg::*;
#(
  parameter logic [7:0] CFG_RESET = 8'h80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_idle,
  input  logic       byte_stb,
  input  logic [7:0] rx_byte,
  input  logic [7:0] rd_byte,
  output logic       tx_load,
  output logic [7:0] tx_word,
  output logic       wr_req,
  output logic [7:0] wr_byte,
  output logic       rd_req,
  output logic [7:0] cfg,
  output logic       aux_led
);

  seq_state_e        state;
  logic [7:0]        pend;
  logic              pend_v;
  logic [IDLE_W-1:0] idle_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_OPCODE;
      cfg       <= CFG_RESET;
      aux_led   <= 1'b0;
      pend      <= '0;
      pend_v    <= 1'b0;
      idle_left <= '0;
      tx_load   <= 1'b0;
      tx_word   <= '0;
      wr_req    <= 1'b0;
      wr_byte   <= '0;
      rd_req    <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      wr_req  <= 1'b0;
      rd_req  <= 1'b0;
      if (frame_idle) begin
        state  <= SQ_OPCODE;
        pend_v <= 1'b0;
      end else if (byte_stb) begin
        unique case (state)
          SQ_OPCODE: begin
            unique case (rx_byte)
              OP_NAND_WR: begin
                state  <= SQ_WRITE;
                pend_v <= 1'b0;
              end
              OP_CFG_WR: state <= SQ_CONFIG;
              OP_NAND_RD: begin
                rd_req    <= 1'b1;
                idle_left <= IDLE_W'(IDLE_BYTES_NORM);
                state     <= SQ_RDWAIT;
              end
              OP_NAND_RD_FAST: begin
                rd_req    <= 1'b1;
                idle_left <= IDLE_W'(IDLE_BYTES_FAST);
                state     <= SQ_RDWAIT;
              end
              OP_AUX_ON: begin
                aux_led <= 1'b1;
                state   <= SQ_DISCARD;
              end
              OP_AUX_OFF: begin
                aux_led <= 1'b0;
                state   <= SQ_DISCARD;
              end
              default: state <= SQ_DISCARD;
            endcase
          end
          SQ_WRITE: begin
            if (pend_v) begin
              wr_req  <= 1'b1;
              wr_byte <= pend;
            end
            pend   <= rx_byte;
            pend_v <= 1'b1;
          end
          SQ_CONFIG: cfg <= rx_byte;
          SQ_RDWAIT: begin
            if (idle_left == IDLE_W'(1)) begin
              tx_word <= rd_byte;
              tx_load <= 1'b1;
              rd_req  <= 1'b1;
              state   <= SQ_RDATA;
            end else begin
              idle_left <= idle_left - 1'b1;
            end
          end
          SQ_RDATA: begin
            tx_word <= rd_byte;
            tx_load <= 1'b1;
            rd_req  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spinand_bridge.sv
module spinand_bridge
  import spinand_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         STROBE_CLKS = 2,
  parameter logic [7:0] CFG_RESET   = 8'h80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic [7:0] nand_dout,
  output logic       nand_doe,
  input  logic [7:0] nand_din,
  output logic       nand_we_n,
  output logic       nand_re_n,
  output logic       nand_ale,
  output logic       nand_cle,
  output logic       nand_ce_n,
  output logic [3:0] led_user,
  output logic       led_aux,
  output logic       fan_en
);

  logic       frame_idle, byte_stb, tx_load, wr_req, rd_req;
  logic [7:0] rx_byte, tx_word, wr_byte, rd_byte, cfg;

  spinand_spi_link #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_link (
    .clk       (clk),
    .rst       (rst),
    .sck       (spi_sck),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .tx_load   (tx_load),
    .tx_word   (tx_word),
    .miso      (spi_miso),
    .frame_idle(frame_idle),
    .byte_stb  (byte_stb),
    .rx_byte   (rx_byte)
  );

  spinand_cmd_seq #(
    .CFG_RESET(CFG_RESET)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .frame_idle(frame_idle),
    .byte_stb  (byte_stb),
    .rx_byte   (rx_byte),
    .rd_byte   (rd_byte),
    .tx_load   (tx_load),
    .tx_word   (tx_word),
    .wr_req    (wr_req),
    .wr_byte   (wr_byte),
    .rd_req    (rd_req),
    .cfg       (cfg),
    .aux_led   (led_aux)
  );

  spinand_nand_port #(
    .STROBE_CLKS(STROBE_CLKS)
  ) u_port (
    .clk      (clk),
    .rst      (rst),
    .wr_req   (wr_req),
    .wr_byte  (wr_byte),
    .rd_req   (rd_req),
    .nand_din (nand_din),
    .nand_dout(nand_dout),
    .nand_doe (nand_doe),
    .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n),
    .rd_byte  (rd_byte)
  );

  assign led_user  = cfg[3:0];
  assign fan_en    = cfg[CFG_FAN];
  assign nand_ale  = cfg[CFG_ALE];
  assign nand_cle  = cfg[CFG_CLE];
  assign nand_ce_n = cfg[CFG_CE_N];

endmodule

// File: rtl/spinand_bridge_checks.sv
module spinand_bridge_checks #(
  parameter int SYNC_STAGES = 2,
  parameter int STROBE_CLKS = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       spi_cs_n,
  input logic       spi_miso,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_doe,
  input logic [7:0] nand_dout
);

  logic [15:0] we_low, re_low;
  logic [3:0]  cs_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_low <= '0;
      re_low <= '0;
      cs_hi  <= '0;
    end else begin
      we_low <= nand_we_n ? 16'd0 : we_low + 16'd1;
      re_low <= nand_re_n ? 16'd0 : re_low + 16'd1;
      if (!spi_cs_n)        cs_hi <= '0;
      else if (cs_hi != '1) cs_hi <= cs_hi + 4'd1;
    end
  end

  // R11
  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));

  // R11
  a_r11_re_width: assert property (@(posedge clk) disable iff (rst)
    (nand_re_n && re_low != 16'd0) |-> (re_low == 16'(STROBE_CLKS)));

  // R4
  a_r4_we_width: assert property (@(posedge clk) disable iff (rst)
    (nand_we_n && we_low != 16'd0) |-> (we_low == 16'(STROBE_CLKS)));

  // R4
  a_r4_oe_covers_we: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |-> nand_doe);

  // R4
  a_r4_data_stable: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dout));

  // R4
  a_r4_oe_release: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_we_n) |=> !nand_doe);

  // R9
  a_r9_miso_quiet: assert property (@(posedge clk) disable iff (rst)
    (32'(cs_hi) > SYNC_STAGES + 2) |-> !spi_miso);

endmodule

bind spinand_bridge spinand_bridge_checks #(
  .SYNC_STAGES(SYNC_STAGES),
  .STROBE_CLKS(STROBE_CLKS)
) u_checks (
  .clk      (clk),
  .rst      (rst),
  .spi_cs_n (spi_cs_n),
  .spi_miso (spi_miso),
  .nand_we_n(nand_we_n),
  .nand_re_n(nand_re_n),
  .nand_doe (nand_doe),
  .nand_dout(nand_dout)
);

// File: tb/spinand_bridge_test.sv
module spinand_bridge_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int STROBE     = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic       spi_miso;
  logic [7:0] nand_dout, nand_din;
  logic       nand_doe, nand_we_n, nand_re_n, nand_ale, nand_cle, nand_ce_n;
  logic [3:0] led_user;
  logic       led_aux, fan_en;

  int tests = 0, fails = 0;
  int rd_ptr = 0, we_cnt = 0, re_cnt = 0, we_low_tot = 0, re_low_tot = 0;
  bit armed = 0, done = 0;
  logic [7:0] txb[16];
  logic [7:0] rxb[16];
  logic [7:0] exp_wr[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spinand_bridge #(.STROBE_CLKS(STROBE)) uut (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .nand_dout(nand_dout),
    .nand_doe(nand_doe), .nand_din(nand_din), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_ale(nand_ale), .nand_cle(nand_cle),
    .nand_ce_n(nand_ce_n), .led_user(led_user), .led_aux(led_aux),
    .fan_en(fan_en)
  );

  function automatic logic [7:0] nand_pat(int k);
    return 8'((k * 29 + 92) & 255);
  endfunction

  assign nand_din = nand_pat(rd_ptr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // NAND model and write monitor (scoreboard pop side)
  always @(posedge nand_re_n) if (armed) begin rd_ptr++; re_cnt++; end
  always @(posedge nand_we_n) if (armed) begin
    we_cnt++;
    tests++;
    if (exp_wr.size() == 0) begin
      fails++;
      $display("FAIL R3 actual=%0h expected=none (unexpected write)", nand_dout);
    end else begin
      logic [7:0] e;
      e = exp_wr.pop_front();
      if (nand_dout !== e || nand_doe !== 1'b1) begin
        fails++;
        $display("FAIL R3/R4 actual=%0h oe=%0b expected=%0h oe=1", nand_dout, nand_doe, e);
      end
    end
  end
  always @(negedge clk) if (armed) begin
    if (!nand_we_n) we_low_tot++;
    if (!nand_re_n) re_low_tot++;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_byte(input logic [7:0] v, input bit collide, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = v[i];
      wait_clk(HALF);
      r[i] = spi_miso;
      spi_sck = 1'b1;
      if (collide && i == 0) spi_cs_n = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic run_frame(input int n, input bit collide_last);
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    for (int j = 0; j < n; j++) begin
      logic [7:0] r;
      xfer_byte(txb[j], collide_last && (j == n - 1), r);
      rxb[j] = r;
    end
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  function automatic logic [7:0] cfg_now();
    return {nand_ce_n, nand_cle, nand_ale, fan_en, led_user};
  endfunction

  task automatic finish_report();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_report();
  end

  initial begin
    int p0, w0, r0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    armed = 1;
    // R2 reset state
    check("R2 cfg", cfg_now(), 8'h80);
    check("R2 aux", led_aux, 0);
    check("R2 strobes", {nand_we_n, nand_re_n, nand_doe}, 3'b110);
    check("R2 miso", spi_miso, 0);

    // R1 config write with field mapping
    txb[0] = 8'h09; txb[1] = 8'h3F; run_frame(2, 0);
    check("R1 leds", led_user, 4'hF);
    check("R1 fan/ale/cle/ce", {fan_en, nand_ale, nand_cle, nand_ce_n}, 4'b1100);
    txb[0] = 8'h09; txb[1] = 8'hA1; txb[2] = 8'h46; run_frame(3, 0);
    check("R1 last byte wins", cfg_now(), 8'h46);

    // R7 aux LED
    txb[0] = 8'h0C; run_frame(1, 0);
    check("R7 aux on", led_aux, 1);
    txb[0] = 8'h0D; run_frame(1, 0);
    check("R7 aux off", led_aux, 0);

    // R3 write with idle flush
    w0 = we_cnt;
    exp_wr.push_back(8'h11); exp_wr.push_back(8'h22); exp_wr.push_back(8'hC3);
    txb[0] = 8'h08; txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'hC3; txb[4] = 8'h00;
    run_frame(5, 0);
    check("R3 write count", we_cnt - w0, 3);
    check("R3 queue drained", exp_wr.size(), 0);
    // R3 final byte without idle is not written
    w0 = we_cnt;
    exp_wr.push_back(8'h44);
    txb[0] = 8'h08; txb[1] = 8'h44; txb[2] = 8'h55; run_frame(3, 0);
    check("R3 last byte dropped", we_cnt - w0, 1);
    check("R3 queue drained 2", exp_wr.size(), 0);
    check("R4 bus released", nand_doe, 0);
    check("R4 we low total", we_low_tot, 4 * STROBE);

    // R5 normal read
    p0 = rd_ptr;
    for (int j = 0; j < 5; j++) txb[j] = 8'h00;
    txb[0] = 8'h0A; run_frame(5, 0);
    check("R5 idle slot", rxb[1], 0);
    for (int j = 0; j < 3; j++) check("R5 data", rxb[2 + j], nand_pat(p0 + j));

    // R6 fast read
    p0 = rd_ptr;
    for (int j = 0; j < 7; j++) txb[j] = 8'h00;
    txb[0] = 8'h0B; run_frame(7, 0);
    for (int j = 1; j < 5; j++) check("R6 idle slot", rxb[j], 0);
    check("R6 data 0", rxb[5], nand_pat(p0));
    check("R6 data 1", rxb[6], nand_pat(p0 + 1));
    check("R11 re low total", re_low_tot, re_cnt * STROBE);

    // R8 unknown opcode
    w0 = we_cnt; r0 = re_cnt;
    txb[0] = 8'h42; txb[1] = 8'h09; txb[2] = 8'h7E; txb[3] = 8'h0C;
    txb[4] = 8'h08; txb[5] = 8'h12; txb[6] = 8'h34; run_frame(7, 0);
    check("R8 cfg kept", cfg_now(), 8'h46);
    check("R8 aux kept", led_aux, 0);
    check("R8 no strobes", (we_cnt - w0) + (re_cnt - r0), 0);
    for (int j = 0; j < 7; j++) check("R8 miso low", rxb[j], 0);

    // R9 partial byte then fresh frame
    spi_cs_n = 1'b0; wait_clk(HALF);
    for (int i = 0; i < 4; i++) begin
      spi_mosi = 1'b1; wait_clk(HALF); spi_sck = 1'b1; wait_clk(HALF); spi_sck = 1'b0;
    end
    wait_clk(HALF); spi_cs_n = 1'b1; wait_clk(4 * HALF);
    check("R9 miso idle", spi_miso, 0);
    txb[0] = 8'h09; txb[1] = 8'h81; run_frame(2, 0);
    check("R9 realigned", cfg_now(), 8'h81);
    txb[0] = 8'h0C; run_frame(1, 0);
    check("R9 opcode wait", {cfg_now(), 7'd0, led_aux}, {8'h81, 8'h01});

    // R10 chip select release with the last SCK edge
    txb[0] = 8'h09; txb[1] = 8'h5A; run_frame(2, 1);
    check("R10 byte discarded", cfg_now(), 8'h81);

    wait_clk(10);
    finish_report();
  end

endmodule